// File: doc/BRIEF.md
# No-Stretch Slave Overrun/Underrun Detector

This block sits between the byte shifter of a two-wire serial slave and the single data register that software reads and writes. It is for slave operation in which the slave may not hold the clock low to gain time. On receive, a byte may finish while software has not yet read the previous one. On transmit, the shifter may need the next byte while software has not yet supplied it. In both cases the bus cannot be paused. The block therefore drops the fresh incoming byte, or hands the previous byte back to the shifter so that it goes out a second time. It records either event in a sticky error flag.

The block keeps one full bit for the data register. A receive load or a software write sets the bit. A software read or a transmit load clears it. Within a cycle, software accesses take effect before the shifter's strobe, so a read or write made in the same cycle as the strobe counts as arriving in time. Software clears the flag with a clear strobe, which stands for writing zero to the flag. Dropping the peripheral enable wipes the flag, the full bit and the stored byte.

Top module: `nsd_top`

## Requirements
- R1: Detection is active only while `enable`, `slave_mode` and `no_stretch` are all 1. With detection off, a receive strobe always loads the byte, a transmit load from an empty register repeats the stored byte, and neither case sets `err_flag`.
- R2: With detection on and `tx_mode`=0, a `rx_done` pulse while the register is full and no `sw_rd` occurs in the same cycle sets `err_flag` on the next cycle. The stored byte and the full bit stay unchanged, so the new byte is discarded.
- R3: With `tx_mode`=0, a `rx_done` pulse while the register is empty, or in the same cycle as `sw_rd`, stores `rx_byte` and sets `dr_full` on the next cycle without touching `err_flag`.
- R4: With detection on and `tx_mode`=1, a `tx_load` pulse while the register is empty and without `sw_wr` in that cycle presents the stored byte on `tx_data` in that cycle. It also sets `err_flag` on the next cycle, and `dr_full` stays 0.
- R5: With `tx_mode`=1, a `tx_load` pulse while the register is full presents the stored byte on `tx_data`. If `sw_wr` occurs in that same cycle, `sw_wdata` is presented instead. In both cases `dr_full` is 0 on the next cycle and no error is raised.
- R6: `sw_wr` stores `sw_wdata` and sets `dr_full`. `sw_rd` clears `dr_full`. When both occur in one cycle, the register ends up full.
- R7: `err_flag` stays set until an `err_clr` pulse. A hardware set in the same cycle as `err_clr` wins.
- R8: While `enable` is 0, on the next edge `err_flag`, `dr_full` and `dr_data` become 0, and all strobes are ignored.
- R9: `rx_done` is ignored while `tx_mode`=1 and `tx_load` is ignored while `tx_mode`=0. Neither changes `dr_full`, `dr_data` or `err_flag`.
- R10: After reset, `err_flag`, `dr_full` and `dr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; 0 wipes all state |
| slave_mode | input | 1 | 1 when operating as slave |
| no_stretch | input | 1 | 1 when clock stretching is disabled |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| rx_done | input | 1 | Shifter finished a byte including its ACK |
| rx_byte | input | DATA_W | Byte from the shifter |
| tx_load | input | 1 | Shifter requests the next byte to send |
| tx_data | output | DATA_W | Byte handed to the shifter (valid with tx_load) |
| sw_rd | input | 1 | Software reads the data register |
| sw_wr | input | 1 | Software writes the data register |
| sw_wdata | input | DATA_W | Software write data |
| err_clr | input | 1 | Software clears the error flag |
| dr_data | output | DATA_W | Data register contents |
| dr_full | output | 1 | Data register holds an unconsumed byte |
| err_flag | output | 1 | Sticky overrun/underrun flag |

## Verification
Directed sequences first send receive bytes that software reads promptly, reads in the same cycle, or never reads. These separate a true overrun from an in-time read. They are followed by transmit loads against a filled register, a same-cycle write and an empty register, which separate a repeated byte from a fresh one. The same patterns are repeated with detection switched off and with strobes from the other direction, to show that only the no-stretch slave case raises the flag. A long random phase then mixes modes, enable drops and clear pulses against a behavioural model, which exposes priority errors between clear and set, and between software and shifter.

// File: rtl/nsd_pkg.sv
package nsd_pkg;
  typedef enum logic [2:0] {
    EV_IDLE,
    EV_RX_STORE,
    EV_RX_DROP,
    EV_TX_TAKE,
    EV_TX_REPEAT
  } nsd_event_e;
endpackage

// File: rtl/nsd_sw_stage.sv
module nsd_sw_stage #(
  parameter int DATA_W = 8
) (
  input  logic              full_q,
  input  logic [DATA_W-1:0] dreg_q,
  input  logic              sw_rd,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic              full_eff,
  output logic [DATA_W-1:0] dreg_eff
);
  // Software accesses are ordered ahead of the shifter within one cycle.
  always_comb begin
    full_eff = full_q;
    dreg_eff = dreg_q;
    if (sw_rd) full_eff = 1'b0;
    if (sw_wr) begin
      full_eff = 1'b1;
      dreg_eff = sw_wdata;
    end
  end
endmodule

// File: rtl/nsd_bus_stage.sv
module nsd_bus_stage
  import nsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              detect_on,
  input  logic              tx_mode,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_load,
  input  logic              full_eff,
  input  logic [DATA_W-1:0] dreg_eff,
  output logic              full_nxt,
  output logic [DATA_W-1:0] dreg_nxt,
  output logic [DATA_W-1:0] tx_data,
  output logic              err_set,
  output nsd_event_e        ev
);
  logic rx_evt, tx_evt;

  assign rx_evt = rx_done & ~tx_mode;
  assign tx_evt = tx_load & tx_mode;
  // An empty register leaves dreg_eff at the previous byte, so it repeats.
  assign tx_data = dreg_eff;

  always_comb begin
    full_nxt = full_eff;
    dreg_nxt = dreg_eff;
    err_set  = 1'b0;
    ev       = EV_IDLE;
    if (rx_evt) begin
      if (full_eff && detect_on) begin
        err_set = 1'b1;
        ev      = EV_RX_DROP;
      end else begin
        full_nxt = 1'b1;
        dreg_nxt = rx_byte;
        ev       = EV_RX_STORE;
      end
    end else if (tx_evt) begin
      full_nxt = 1'b0;
      if (!full_eff && detect_on) begin
        err_set = 1'b1;
        ev      = EV_TX_REPEAT;
      end else begin
        ev      = EV_TX_TAKE;
      end
    end
  end

  // Combinational consistency of the decision outputs.
  always_comb begin
    if (ev == EV_TX_REPEAT) begin
      assert (!full_eff && detect_on) else $error("AST_REPEAT_ONLY_EMPTY");  // R4
    end
    if (ev == EV_RX_DROP) begin
      assert (full_nxt) else $error("AST_DROP_KEEPS_FULL");                 // R2
    end
  end
endmodule

// File: rtl/nsd_err_flag.sv
module nsd_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (!enable)     flag_d = 1'b0;
    else if (set_i)  flag_d = 1'b1;
    else if (clr_i)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && enable && !clr_i) |=> flag_q);                               // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && set_i) |=> flag_q);                                          // R7
endmodule

// File: rtl/nsd_top.sv
module nsd_top
  import nsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              slave_mode,
  input  logic              no_stretch,
  input  logic              tx_mode,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              tx_load,
  output logic [DATA_W-1:0] tx_data,
  input  logic              sw_rd,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              err_clr,
  output logic [DATA_W-1:0] dr_data,
  output logic              dr_full,
  output logic              err_flag
);
  localparam logic [DATA_W-1:0] ZERO_BYTE = '0;

  logic              full_q, full_d;
  logic [DATA_W-1:0] dreg_q, dreg_d;
  logic              full_eff, full_nxt;
  logic [DATA_W-1:0] dreg_eff, dreg_nxt;
  logic              detect_on, err_set;
  logic              rd_g, wr_g, rx_g, tx_g, clr_g;
  nsd_event_e        ev;

  // Strobes are masked while the peripheral is off.
  assign rd_g      = sw_rd   & enable;
  assign wr_g      = sw_wr   & enable;
  assign rx_g      = rx_done & enable;
  assign tx_g      = tx_load & enable;
  assign clr_g     = err_clr & enable;
  assign detect_on = enable & slave_mode & no_stretch;

  nsd_sw_stage #(.DATA_W(DATA_W)) u_sw (
    .full_q   (full_q),
    .dreg_q   (dreg_q),
    .sw_rd    (rd_g),
    .sw_wr    (wr_g),
    .sw_wdata (sw_wdata),
    .full_eff (full_eff),
    .dreg_eff (dreg_eff)
  );

  nsd_bus_stage #(.DATA_W(DATA_W)) u_bus (
    .detect_on (detect_on),
    .tx_mode   (tx_mode),
    .rx_done   (rx_g),
    .rx_byte   (rx_byte),
    .tx_load   (tx_g),
    .full_eff  (full_eff),
    .dreg_eff  (dreg_eff),
    .full_nxt  (full_nxt),
    .dreg_nxt  (dreg_nxt),
    .tx_data   (tx_data),
    .err_set   (err_set),
    .ev        (ev)
  );

  nsd_err_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .set_i  (err_set),
    .clr_i  (clr_g),
    .flag_o (err_flag)
  );

  always_comb begin
    if (enable) begin
      full_d = full_nxt;
      dreg_d = dreg_nxt;
    end else begin
      full_d = 1'b0;
      dreg_d = ZERO_BYTE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      dreg_q <= ZERO_BYTE;
    end else begin
      full_q <= full_d;
      dreg_q <= dreg_d;
    end
  end

  assign dr_data = dreg_q;
  assign dr_full = full_q;

  AST_OVERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_on && !tx_mode && rx_done && dr_full && !sw_rd && !sw_wr)
      |=> (err_flag && dr_full && $stable(dr_data)));                       // R2
  AST_UNDERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_on && tx_mode && tx_load && !dr_full && !sw_wr)
      |=> (err_flag && !dr_full && $stable(dr_data)));                      // R4
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!(slave_mode && no_stretch) && !err_flag && !tx_mode && rx_done && enable)
      |=> (!err_flag && dr_full));                                          // R1
  AST_DISABLE_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!err_flag && !dr_full && dr_data == '0));                  // R8
  AST_TX_TAKES_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tx_mode && tx_load && !rx_done) |=> !dr_full);               // R5
endmodule

// File: tb/nsd_top_tb.sv
module nsd_top_tb_top;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, slave_mode, no_stretch, tx_mode;
  logic rx_done, tx_load, sw_rd, sw_wr, err_clr;
  logic [DATA_W-1:0] rx_byte, sw_wdata, tx_data, dr_data;
  logic dr_full, err_flag;

  int n_run  = 0;
  int n_fail = 0;

  // Behavioural reference state
  bit       m_full;
  bit [7:0] m_dr;
  bit       m_err;
  string    m_tag;

  always #5 clk = ~clk;

  nsd_top #(.DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slave_mode(slave_mode),
    .no_stretch(no_stretch), .tx_mode(tx_mode), .rx_done(rx_done),
    .rx_byte(rx_byte), .tx_load(tx_load), .tx_data(tx_data),
    .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .err_clr(err_clr),
    .dr_data(dr_data), .dr_full(dr_full), .err_flag(err_flag)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check tx_data, advance model, compare after edge.
  task automatic step(bit en, bit sl, bit ns, bit tx, bit rxd, bit [7:0] rxb,
                      bit tl, bit rd, bit wr, bit [7:0] wd, bit clr);
    bit f, det, set, other;
    bit [7:0] d;
    enable = en; slave_mode = sl; no_stretch = ns; tx_mode = tx;
    rx_done = rxd; rx_byte = rxb; tx_load = tl; sw_rd = rd; sw_wr = wr;
    sw_wdata = wd; err_clr = clr;
    #1;
    set = 0; other = 0;
    if (!en) begin
      m_full = 0; m_dr = 0; m_err = 0; m_tag = "R8";
    end else begin
      det = sl && ns;
      f = m_full; d = m_dr;
      m_tag = "R6";
      if (rd) f = 0;
      if (wr) begin f = 1; d = wd; end
      if (!tx && rxd) begin
        if (f && det) begin set = 1; m_tag = "R2"; end
        else begin f = 1; d = rxb; m_tag = det ? "R3" : "R1"; end
      end else if (tx && tl) begin
        if (!f && det) begin set = 1; m_tag = "R4"; end
        else m_tag = det ? "R5" : "R1";
        check((!f && det) ? "R4" : "R5", "tx_data", tx_data, d);
        f = 0;
      end else if (rxd || tl) begin
        m_tag = "R9"; other = 1;
      end
      if (set) m_err = 1;
      else if (clr) begin m_err = 0; if (!other) m_tag = "R7"; end
      m_full = f; m_dr = d;
    end
    @(negedge clk);
    check(m_tag, "dr_full", dr_full, m_full);
    check(m_tag, "dr_data", dr_data, m_dr);
    check(m_tag, "err_flag", err_flag, m_err);
  endtask

  task automatic idle(bit tx);
    step(1, 1, 1, tx, 0, 8'h00, 0, 0, 0, 8'h00, 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; slave_mode = 0; no_stretch = 0; tx_mode = 0;
    rx_done = 0; rx_byte = 0; tx_load = 0; sw_rd = 0; sw_wr = 0;
    sw_wdata = 0; err_clr = 0;
    m_full = 0; m_dr = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", "dr_full", dr_full, 0);
    check("R10", "dr_data", dr_data, 0);
    check("R10", "err_flag", err_flag, 0);
    rst_n = 1;
    @(negedge clk);

    // Receive: prompt read, same-cycle read, overrun (R3, R2)
    step(1, 1, 1, 0, 1, 8'hA1, 0, 0, 0, 8'h00, 0);
    step(1, 1, 1, 0, 0, 8'h00, 0, 1, 0, 8'h00, 0);
    step(1, 1, 1, 0, 1, 8'hB2, 0, 0, 0, 8'h00, 0);
    step(1, 1, 1, 0, 1, 8'hC3, 0, 1, 0, 8'h00, 0);
    step(1, 1, 1, 0, 1, 8'hD4, 0, 0, 0, 8'h00, 0);   // R2 overrun, D4 dropped
    idle(0);
    step(1, 1, 1, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1);   // R7 clear
    // Set wins over clear (R7)
    step(1, 1, 1, 0, 1, 8'hE5, 0, 0, 0, 8'h00, 1);
    step(1, 1, 1, 0, 0, 8'h00, 0, 0, 0, 8'h00, 1);
    // Transmit: filled, same-cycle write, empty repeat (R5, R4)
    step(1, 1, 1, 1, 0, 8'h00, 0, 0, 1, 8'h11, 0);
    step(1, 1, 1, 1, 0, 8'h00, 1, 0, 0, 8'h00, 0);
    step(1, 1, 1, 1, 0, 8'h00, 1, 0, 1, 8'h22, 0);
    step(1, 1, 1, 1, 0, 8'h00, 1, 0, 0, 8'h00, 0);   // R4 repeat 22
    idle(1);
    // Other-direction strobes ignored (R9)
    step(1, 1, 1, 1, 1, 8'h77, 0, 0, 0, 8'h00, 0);
    step(1, 1, 1, 0, 0, 8'h00, 1, 0, 0, 8'h00, 0);
    // Software tracking (R6)
    step(1, 1, 1, 0, 0, 8'h00, 0, 1, 1, 8'h5A, 0);
    step(1, 1, 1, 0, 0, 8'h00, 0, 1, 0, 8'h00, 0);
    // Disable wipes, strobes ignored (R8)
    step(0, 1, 1, 0, 1, 8'h99, 0, 0, 1, 8'h66, 0);
    // Detection off: no flag (R1)
    step(1, 0, 1, 0, 1, 8'h31, 0, 0, 0, 8'h00, 0);
    step(1, 0, 1, 0, 1, 8'h32, 0, 0, 0, 8'h00, 0);
    step(1, 1, 0, 1, 0, 8'h00, 1, 0, 0, 8'h00, 0);
    step(1, 1, 0, 1, 0, 8'h00, 1, 0, 0, 8'h00, 0);

    // Random phase against the model
    for (int i = 0; i < 4000; i++) begin
      bit en = ($urandom_range(0, 39) != 0);
      bit sl = ($urandom_range(0, 7) != 0);
      bit ns = ($urandom_range(0, 7) != 0);
      step(en, sl, ns, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0, 8'($urandom),
           $urandom_range(0, 2) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           8'($urandom), $urandom_range(0, 9) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule